// File: doc/BRIEF.md
# Thermal limit monitor with fan override

This block watches two 8-bit two's-complement temperature channels, a local one and a remote one, at 1 °C per count. A new pair of samples arrives with a one-cycle strobe, nominally once per monitoring period of about a second. Each sample is compared as a signed number against a high limit, a low limit and a critical limit for its channel. Limit violations are latched into a sticky status register. An active-low interrupt is driven from that register through per-source masks, a separate pin mask and a global enable.

A critical-persistence state machine counts consecutive strobes on which either channel is above its critical limit. It has three states: `PS_COOL`, `PS_WARMING` and `PS_TRIPPED`. A critical strobe moves `PS_COOL` to `PS_WARMING`. In `PS_WARMING`, each further critical strobe advances the count, and the count reaching `PERSIST_CYCLES` moves it to `PS_TRIPPED`. A non-critical strobe from either `PS_WARMING` or `PS_TRIPPED` returns it to `PS_COOL` with the count at zero. Cycles without a strobe hold the state. In `PS_TRIPPED` the block pulls the thermal line low. While the line is low from either side, the fan code is forced to full scale and the fan-off request is released. An outside device that pulls the line low also sets a status bit.

Software reaches the block through a simple register port: address, write strobe, write data, read strobe and registered read data. The read data appears on the clock edge that takes the read strobe.

Top module: `thermal_guard`

## Requirements
- R1: On a strobe, a channel sample greater (signed) than its high limit sets its over bit at the same clock edge. Local over is status bit 0 and remote over is bit 2. A sample equal to the limit sets nothing. The local high limit is at 0x20 and the remote high limit at 0x22, both reset to 0x7F.
- R2: On a strobe, a sample less (signed) than its low limit sets its under bit: local bit 1, remote bit 3. The local low limit is at 0x21 and the remote low limit at 0x23, both reset to 0x80.
- R3: Status bits 0-3, 5 and 6 stay set until cleared. Writing status address 0x41 clears each bit written as 1. Reading 0x41 returns the current value and then clears all latched bits.
- R4: Address 0x4C returns the same status value as 0x41, and reading it clears nothing.
- R5: `irq_n` is low exactly when config bit 1 is 1, mask bit 7 is 0, and some latched status bit is set whose mask bit (same position, mask register 0x43) is 0. Config (0x40) and mask reset to 0x00.
- R6: `therm_out_n` goes low after `PERSIST_CYCLES` (3) consecutive strobes on which local > local critical (0x24, reset 0x46) or remote > remote critical (0x25, reset 0x5A). A non-critical strobe releases it and restarts the count, and cycles without a strobe change nothing. Entering the tripped state sets status bit 6.
- R7: A low `therm_in_n` sets status bit 5, forces `fan_code` to 0xFF and drives `fan_off_n` high.
- R8: With the thermal line high and reset released, `fan_code` equals the fan register at 0x26. It is 0xFF whenever `therm_in_n` or `therm_out_n` is low.
- R9: While `rst_n` is low, `fan_code` is 0x00, `irq_n` and `therm_out_n` are high, and `fan_off_n` is low. If `therm_in_n` is low during that time, `fan_code` is 0xFF and `fan_off_n` is high.
- R10: Status bit 4 shows `gpi` live. It is inverted when config bit 6 is 1 and is never latched.
- R11: With the thermal line high, `fan_off_n` equals config bit 5, and that bit does not change `fan_code`.
- R12: Addresses 0x27 (local) and 0x28 (remote) return the samples taken at the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (clears status on 0x41) |
| reg_rdata | output | 8 | Registered read data |
| samp_valid | input | 1 | One-cycle strobe: both samples are valid |
| samp_local | input | 8 | Local temperature, two's complement |
| samp_remote | input | 8 | Remote temperature, two's complement |
| therm_in_n | input | 1 | Level seen on the thermal line (low = overload) |
| therm_out_n | output | 1 | Open-drain pull-down request for the thermal line |
| gpi | input | 1 | General-purpose input reflected in status |
| irq_n | output | 1 | Active-low interrupt |
| fan_code | output | 8 | Fan speed code to the DAC |
| fan_off_n | output | 1 | Low requests fan off |

## Verification
The comparators are swept over all 256 local sample values against a window of +10/-10. A scrambled sweep of remote values runs at the same time against a negative window of -20/-60. Every status nibble and the interrupt level are predicted arithmetically, so the sweep separates signed from unsigned compares and strict from inclusive bounds. The persistence machine is driven with unbroken critical runs, runs broken by one cool strobe, and critical values held without a strobe, on each channel. These show that only consecutive strobes count and that an equal-to-critical sample releases the line. Clear-by-write, clear-by-read, the mirror, the mask, the GPI polarity and the external thermal pull are each tried against the value they should leave in status.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
    localparam int DW     = 8;
    localparam int ADDR_W = 8;
    localparam int NCH    = 2;  // channel 0 = local, channel 1 = remote

    localparam logic [ADDR_W-1:0] ADDR_LIM_BASE  = 8'h20; // hi/lo pairs per channel
    localparam logic [ADDR_W-1:0] ADDR_CRIT_BASE = 8'h24;
    localparam logic [ADDR_W-1:0] ADDR_FAN       = 8'h26;
    localparam logic [ADDR_W-1:0] ADDR_TEMP_BASE = 8'h27;
    localparam logic [ADDR_W-1:0] ADDR_CFG       = 8'h40;
    localparam logic [ADDR_W-1:0] ADDR_STAT      = 8'h41;
    localparam logic [ADDR_W-1:0] ADDR_MASK      = 8'h43;
    localparam logic [ADDR_W-1:0] ADDR_MIRROR    = 8'h4C;

    localparam int CFG_IRQ_EN  = 1;
    localparam int CFG_FAN_RUN = 5;
    localparam int CFG_GPI_INV = 6;
    localparam int ST_GPI      = 4;
    localparam int ST_EXT      = 5;
    localparam int ST_CRIT     = 6;
    localparam int MASK_PIN    = 7;

    typedef enum logic [1:0] {
        PS_COOL,
        PS_WARMING,
        PS_TRIPPED
    } persist_state_t;
endpackage

// File: rtl/thermal_limit_cmp.sv
module thermal_limit_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] hi_lim,
    input  logic [W-1:0] lo_lim,
    input  logic [W-1:0] crit_lim,
    output logic         over,
    output logic         under,
    output logic         crit_hit
);
    always_comb begin
        over     = $signed(sample) > $signed(hi_lim);
        under    = $signed(sample) < $signed(lo_lim);
        crit_hit = $signed(sample) > $signed(crit_lim);
    end
endmodule

// File: rtl/thermal_persist_fsm.sv
module thermal_persist_fsm
    import thermal_guard_pkg::*;
#(
    parameter int PERSIST = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic crit,
    output logic trip_n,
    output logic trip_event
);
    localparam int CW = $clog2(PERSIST + 1);

    persist_state_t state_q, state_n;
    logic [CW-1:0]  cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_COOL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            PS_COOL: begin
                if (valid && crit) begin
                    if (PERSIST <= 1) begin
                        state_n = PS_TRIPPED;
                        cnt_n   = '0;
                    end else begin
                        state_n = PS_WARMING;
                        cnt_n   = CW'(1);
                    end
                end
            end
            PS_WARMING: begin
                if (valid) begin
                    if (!crit) begin
                        state_n = PS_COOL;
                        cnt_n   = '0;
                    end else if (cnt_q + 1'b1 >= CW'(PERSIST)) begin
                        state_n = PS_TRIPPED;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            PS_TRIPPED: begin
                if (valid && !crit) begin
                    state_n = PS_COOL;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = PS_COOL;
                cnt_n   = '0;
            end
        endcase
    end

    always_comb begin
        trip_n     = (state_q != PS_TRIPPED);
        trip_event = (state_q != PS_TRIPPED) && (state_n == PS_TRIPPED);
    end

    a_r6_trip_needs_crit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trip_n) |-> $past(valid && crit));
    a_r6_cool_release: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !crit) |=> trip_n);
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(trip_n));
endmodule

// File: rtl/thermal_regfile.sv
module thermal_regfile
    import thermal_guard_pkg::*;
#(
    parameter logic [NCH-1:0][DW-1:0] HI_INIT   = {NCH{8'h7F}},
    parameter logic [NCH-1:0][DW-1:0] LO_INIT   = {NCH{8'h80}},
    parameter logic [NCH-1:0][DW-1:0] CRIT_INIT = {8'h5A, 8'h46}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr,
    input  logic [DW-1:0]            wdata,
    input  logic                     rd,
    output logic [DW-1:0]            rdata,
    input  logic                     samp_valid,
    input  logic [NCH-1:0][DW-1:0]   samples,
    input  logic [NCH-1:0]           over,
    input  logic [NCH-1:0]           under,
    input  logic                     trip_event,
    input  logic                     ext_low,
    input  logic                     gpi,
    output logic [NCH-1:0][DW-1:0]   hi_lim,
    output logic [NCH-1:0][DW-1:0]   lo_lim,
    output logic [NCH-1:0][DW-1:0]   crit_lim,
    output logic [DW-1:0]            fan_reg,
    output logic                     fan_run,
    output logic                     irq_n
);
    localparam logic [DW-1:0] LATCH_MASK = DW'((1 << (2 * NCH)) - 1)
                                         | (DW'(1) << ST_EXT)
                                         | (DW'(1) << ST_CRIT);

    logic [DW-1:0]          cfg_q, mask_q, fan_q, stat_q, stat_n, stat_view;
    logic [DW-1:0]          set_v, clr_v, rd_val, irq_src;
    logic [NCH-1:0][DW-1:0] hi_q, lo_q, crit_q, temp_q;

    // configuration, limits, fan code, sample capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mask_q <= '0;
            fan_q  <= '0;
            hi_q   <= HI_INIT;
            lo_q   <= LO_INIT;
            crit_q <= CRIT_INIT;
            temp_q <= '0;
        end else begin
            if (wr) begin
                if (addr == ADDR_CFG)  cfg_q  <= wdata;
                if (addr == ADDR_MASK) mask_q <= wdata;
                if (addr == ADDR_FAN)  fan_q  <= wdata;
                for (int ch = 0; ch < NCH; ch++) begin
                    if (addr == ADDR_LIM_BASE + ADDR_W'(2 * ch))     hi_q[ch]   <= wdata;
                    if (addr == ADDR_LIM_BASE + ADDR_W'(2 * ch + 1)) lo_q[ch]   <= wdata;
                    if (addr == ADDR_CRIT_BASE + ADDR_W'(ch))        crit_q[ch] <= wdata;
                end
            end
            if (samp_valid) temp_q <= samples;
        end
    end

    // sticky status: set events win over clears in the same cycle
    always_comb begin
        set_v = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            set_v[2 * ch]     = samp_valid && over[ch];
            set_v[2 * ch + 1] = samp_valid && under[ch];
        end
        set_v[ST_EXT]  = ext_low;
        set_v[ST_CRIT] = trip_event;
        clr_v = '0;
        if (wr && addr == ADDR_STAT) clr_v = wdata;
        if (rd && addr == ADDR_STAT) clr_v = '1;
        stat_n = ((stat_q & ~clr_v) | set_v) & LATCH_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_n;
    end

    always_comb begin
        stat_view         = stat_q & LATCH_MASK;
        stat_view[ST_GPI] = gpi ^ cfg_q[CFG_GPI_INV];
    end

    always_comb begin
        rd_val = '0;
        case (addr)
            ADDR_CFG:                rd_val = cfg_q;
            ADDR_STAT, ADDR_MIRROR:  rd_val = stat_view;
            ADDR_MASK:               rd_val = mask_q;
            ADDR_FAN:                rd_val = fan_q;
            default:                 rd_val = '0;
        endcase
        for (int ch = 0; ch < NCH; ch++) begin
            if (addr == ADDR_LIM_BASE + ADDR_W'(2 * ch))     rd_val = hi_q[ch];
            if (addr == ADDR_LIM_BASE + ADDR_W'(2 * ch + 1)) rd_val = lo_q[ch];
            if (addr == ADDR_CRIT_BASE + ADDR_W'(ch))        rd_val = crit_q[ch];
            if (addr == ADDR_TEMP_BASE + ADDR_W'(ch))        rd_val = temp_q[ch];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_val;
    end

    always_comb begin
        irq_src  = stat_q & LATCH_MASK & ~mask_q;
        irq_n    = !(cfg_q[CFG_IRQ_EN] && !mask_q[MASK_PIN] && (|irq_src));
        hi_lim   = hi_q;
        lo_lim   = lo_q;
        crit_lim = crit_q;
        fan_reg  = fan_q;
        fan_run  = cfg_q[CFG_FAN_RUN];
    end

    a_r1_over_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && over[0]) |=> stat_q[0]);
    a_r2_under_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && under[NCH-1]) |=> stat_q[2 * NCH - 1]);
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !(wr && addr == ADDR_STAT) && !(rd && addr == ADDR_STAT)) |=> stat_q[0]);
    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[CFG_IRQ_EN] |-> irq_n);
    a_r7_ext_latched: assert property (@(posedge clk) disable iff (!rst_n)
        ext_low |=> stat_q[ST_EXT]);
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_guard_pkg::*;
#(
    parameter int          PERSIST_CYCLES   = 3,
    parameter logic [DW-1:0] LOCAL_CRIT_INIT  = 8'h46,
    parameter logic [DW-1:0] REMOTE_CRIT_INIT = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              reg_rd,
    output logic [DW-1:0]     reg_rdata,
    input  logic              samp_valid,
    input  logic [DW-1:0]     samp_local,
    input  logic [DW-1:0]     samp_remote,
    input  logic              therm_in_n,
    output logic              therm_out_n,
    input  logic              gpi,
    output logic              irq_n,
    output logic [DW-1:0]     fan_code,
    output logic              fan_off_n
);
    logic [NCH-1:0][DW-1:0] samples, hi_lim, lo_lim, crit_lim;
    logic [NCH-1:0]         over, under, crit_hit;
    logic [DW-1:0]          fan_reg;
    logic                   fan_run, trip_event, therm_low;

    assign samples = {samp_remote, samp_local};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        thermal_limit_cmp #(.W(DW)) u_cmp (
            .sample   (samples[ch]),
            .hi_lim   (hi_lim[ch]),
            .lo_lim   (lo_lim[ch]),
            .crit_lim (crit_lim[ch]),
            .over     (over[ch]),
            .under    (under[ch]),
            .crit_hit (crit_hit[ch])
        );
    end

    thermal_persist_fsm #(.PERSIST(PERSIST_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (samp_valid),
        .crit       (|crit_hit),
        .trip_n     (therm_out_n),
        .trip_event (trip_event)
    );

    thermal_regfile #(
        .CRIT_INIT ({REMOTE_CRIT_INIT, LOCAL_CRIT_INIT})
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .rd         (reg_rd),
        .rdata      (reg_rdata),
        .samp_valid (samp_valid),
        .samples    (samples),
        .over       (over),
        .under      (under),
        .trip_event (trip_event),
        .ext_low    (!therm_in_n),
        .gpi        (gpi),
        .hi_lim     (hi_lim),
        .lo_lim     (lo_lim),
        .crit_lim   (crit_lim),
        .fan_reg    (fan_reg),
        .fan_run    (fan_run),
        .irq_n      (irq_n)
    );

    always_comb begin
        therm_low = !therm_in_n || !therm_out_n;
        if (therm_low)   fan_code = '1;
        else if (!rst_n) fan_code = '0;
        else             fan_code = fan_reg;
        fan_off_n = therm_low || fan_run;
    end

    a_r8_fan_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!therm_in_n || !therm_out_n) |-> (fan_code == '1 && fan_off_n));
endmodule

// File: tb/thermal_guard_test.sv
module thermal_guard_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] reg_addr = 0, reg_wdata = 0, samp_local = 0, samp_remote = 0;
    logic       reg_wr = 0, reg_rd = 0, samp_valid = 0, therm_in_n = 1, gpi = 0;
    logic [7:0] reg_rdata, fan_code;
    logic       therm_out_n, irq_n, fan_off_n;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    thermal_guard uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .samp_valid(samp_valid), .samp_local(samp_local), .samp_remote(samp_remote),
        .therm_in_n(therm_in_n), .therm_out_n(therm_out_n), .gpi(gpi),
        .irq_n(irq_n), .fan_code(fan_code), .fan_off_n(fan_off_n)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic smp(logic [7:0] l, logic [7:0] r);
        @(negedge clk); samp_local = l; samp_remote = r; samp_valid = 1;
        @(negedge clk); samp_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        // R9 reset behaviour
        repeat (3) @(negedge clk);
        chk("R9 fan zero in reset", fan_code, 8'h00);
        chk("R9 irq idle", irq_n, 1);
        chk("R9 therm idle", therm_out_n, 1);
        chk("R9 fan_off low", fan_off_n, 0);
        therm_in_n = 0; #1;
        chk("R9 fan full in reset when thermal low", fan_code, 8'hFF);
        chk("R9 fan_off released", fan_off_n, 1);
        therm_in_n = 1;
        @(negedge clk); rst_n = 1;
        rd(8'h40, d); chk("R5 cfg default", d, 8'h00);
        rd(8'h43, d); chk("R5 mask default", d, 8'h00);
        rd(8'h24, d); chk("R6 local crit default", d, 8'h46);
        rd(8'h20, d); chk("R1 hi default", d, 8'h7F);
        rd(8'h23, d); chk("R2 lo default", d, 8'h80);
        rd(8'h41, d); chk("R3 status clear after reset", d, 8'h00);

        // R11 / R8
        wr(8'h40, 8'h20); #1;
        chk("R11 fan_off follows cfg5", fan_off_n, 1);
        chk("R11 fan code unchanged", fan_code, 8'h00);
        wr(8'h26, 8'h5A); #1;
        chk("R8 fan code from reg", fan_code, 8'h5A);
        wr(8'h40, 8'h00); #1;
        chk("R11 fan_off low", fan_off_n, 0);
        wr(8'h40, 8'h20);

        // R12
        smp(8'h11, 8'hF0);
        rd(8'h27, d); chk("R12 local sample", d, 8'h11);
        rd(8'h28, d); chk("R12 remote sample", d, 8'hF0);
        rd(8'h41, d); chk("R1 no violation at default limits", d, 8'h00);

        // R10
        gpi = 1;
        rd(8'h41, d); chk("R10 gpi pass", d, 8'h10);
        wr(8'h40, 8'h60);
        rd(8'h41, d); chk("R10 gpi inverted high", d, 8'h00);
        gpi = 0;
        rd(8'h41, d); chk("R10 gpi inverted low", d, 8'h10);
        wr(8'h40, 8'h20);

        // R3 / R4
        wr(8'h20, 8'h0A);
        smp(8'd11, 8'd0);
        rd(8'h4C, d); chk("R4 mirror", d, 8'h01);
        rd(8'h4C, d); chk("R4 mirror no clear", d, 8'h01);
        wr(8'h41, 8'h02);
        rd(8'h4C, d); chk("R3 w1c other bit keeps", d, 8'h01);
        wr(8'h41, 8'h01);
        rd(8'h4C, d); chk("R3 w1c clears", d, 8'h00);
        smp(8'd11, 8'd0);
        rd(8'h41, d); chk("R3 read returns", d, 8'h01);
        rd(8'h41, d); chk("R3 read cleared", d, 8'h00);
        smp(8'd10, 8'd0);
        rd(8'h41, d); chk("R1 equal not over", d, 8'h00);

        // R5
        smp(8'd11, 8'd0);
        chk("R5 irq disabled", irq_n, 1);
        wr(8'h40, 8'h22); #1;
        chk("R5 irq asserted", irq_n, 0);
        wr(8'h43, 8'h01); #1;
        chk("R5 source masked", irq_n, 1);
        wr(8'h43, 8'h80); #1;
        chk("R5 pin masked", irq_n, 1);
        wr(8'h43, 8'h00); #1;
        chk("R5 unmasked", irq_n, 0);
        rd(8'h41, d); #1;
        chk("R5 cleared irq", irq_n, 1);

        // R6 persistence
        wr(8'h40, 8'h00);
        wr(8'h20, 8'h7F);
        wr(8'h24, 8'd30);
        smp(8'd31, 8'd0); smp(8'd31, 8'd0);
        chk("R6 two strobes not tripped", therm_out_n, 1);
        smp(8'd31, 8'd0);
        chk("R6 third strobe trips", therm_out_n, 0);
        chk("R8 fan full when tripped", fan_code, 8'hFF);
        chk("R7 fan_off released when tripped", fan_off_n, 1);
        rd(8'h41, d); chk("R6 crit status", d, 8'h40);
        smp(8'd30, 8'd0);
        chk("R6 equal releases", therm_out_n, 1);
        chk("R8 fan back", fan_code, 8'h5A);
        smp(8'd31, 8'd0); smp(8'd31, 8'd0); smp(8'd20, 8'd0);
        smp(8'd31, 8'd0); smp(8'd31, 8'd0);
        chk("R6 broken run restarts", therm_out_n, 1);
        samp_local = 8'd31;
        repeat (5) @(negedge clk);
        chk("R6 no strobe no count", therm_out_n, 1);
        smp(8'd31, 8'd0);
        chk("R6 third consecutive strobe", therm_out_n, 0);
        smp(8'd0, 8'd0);
        chk("R6 release", therm_out_n, 1);
        wr(8'h24, 8'h7F);
        wr(8'h25, 8'hF6);
        smp(8'd0, 8'hF7); smp(8'd0, 8'hF7);
        chk("R6 remote two", therm_out_n, 1);
        smp(8'd0, 8'hF7);
        chk("R6 remote trips", therm_out_n, 0);
        smp(8'd0, 8'hF6);
        chk("R6 remote equal releases", therm_out_n, 1);
        wr(8'h25, 8'h7F);

        // R7 external thermal
        rd(8'h41, d);
        @(negedge clk); therm_in_n = 0; #1;
        chk("R7 fan full", fan_code, 8'hFF);
        chk("R7 fan_off released", fan_off_n, 1);
        @(negedge clk); therm_in_n = 1;
        rd(8'h41, d); chk("R7 ext status", d, 8'h20);
        chk("R8 fan restored", fan_code, 8'h5A);

        // R1 R2 R5 sweep
        wr(8'h20, 8'd10);  wr(8'h21, 8'hF6);
        wr(8'h22, 8'hEC);  wr(8'h23, 8'hC4);
        wr(8'h40, 8'h02);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] l, r, e;
            l = 8'(i);
            r = 8'(i * 37 + 5);
            e = 0;
            e[0] = $signed(l) > 10;
            e[1] = $signed(l) < -10;
            e[2] = $signed(r) > -20;
            e[3] = $signed(r) < -60;
            smp(l, r);
            chk("R5 sweep irq", irq_n, !(|e));
            rd(8'h41, d);
            chk("R1 R2 sweep status", d & 8'h0F, e);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule